// File: doc/BRIEF.md
# Non-overlapping two-phase drive sequencer

This block produces two gate-drive lines for a push-pull power stage from one fast clock. A ten-position ring advances by one position on every enabled clock edge. The first drive line is high for four consecutive positions and the second drive line is high for four other consecutive positions. The two remaining positions sit between the groups and keep both lines low. The two lines therefore never overlap, and each one is preceded by a dead gap of one clock.

The output period is always ten input clocks, so the input clock must run at ten times the wanted switching frequency. A one-cycle strobe marks the start of each period. When enable is low, the ring holds its position and both drives are forced low. A synchronous reset parks the ring in its idle wrap position.

Top module: `pp_drive_seq`

## Requirements
- R1: Positions are numbered 0 to 9, and position 0 is the idle wrap position. Each rising clock edge with `rst` low and `en` high moves the position from p to (p+1) mod 10. `cyc_strobe` is high for exactly the one cycle after an edge that moved the position from 9 to 0.
- R2: After an enabled edge, `drv_a` is high exactly when the new position is 1, 2, 3 or 4.
- R3: After an enabled edge, `drv_b` is high exactly when the new position is 6, 7, 8 or 9.
- R4: In positions 0 and 5, `drv_a` and `drv_b` are both low.
- R5: `drv_a` and `drv_b` are never high in the same cycle.
- R6: An edge with `rst` high sets the position to 0, whatever `en` is, and drives `drv_a`, `drv_b` and `cyc_strobe` low.
- R7: An edge with `rst` low and `en` low leaves the position unchanged and drives `drv_a`, `drv_b` and `cyc_strobe` low.
- R8: The first enabled edge after one or more disabled edges advances from the held position, so the drive pattern continues where it stopped.
- R9: `cyc_strobe` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, ten times the output frequency |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low holds the position and silences both drives |
| drv_a | output | 1 | Registered first-phase gate drive |
| drv_b | output | 1 | Registered second-phase gate drive |
| cyc_strobe | output | 1 | One-cycle pulse on entry to position 0 by wrapping |

## Verification
A long uninterrupted enabled run shows the full ten-position pattern repeating: both four-wide groups, both single-clock gaps, and a strobe every ten clocks. Holds placed in the middle of a drive group, and holds placed just before the wrap, separate a design that remembers its position from one that restarts or slips. Holds placed before the wrap also show whether the strobe is held back until the wrap really happens. Enable that alternates on every clock, or follows a pseudo-random pattern, mixes the hold and drive-silencing paths with stepping. A reset in the middle of a period, with enable held high, shows that reset takes priority and that the ring restarts at the idle position.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;

  typedef enum logic [1:0] {
    GRP_IDLE = 2'd0,
    GRP_A    = 2'd1,
    GRP_B    = 2'd2
  } grp_e;

  // Which drive group a ring position belongs to
  function automatic grp_e grp_of(input int idx, input int a_lo, input int a_hi,
                                  input int b_lo, input int b_hi);
    if (idx >= a_lo && idx <= a_hi) return GRP_A;
    if (idx >= b_lo && idx <= b_hi) return GRP_B;
    return GRP_IDLE;
  endfunction

endpackage

// File: rtl/pp_ring.sv
module pp_ring #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [N-1:0] st_q,
  output logic [N-1:0] st_nxt,
  output logic         step,
  output logic         wrap_evt
);
  localparam logic [N-1:0] IDLE_HOT = {{(N-1){1'b0}}, 1'b1};

  logic legal;

  // exactly one bit set
  function automatic logic one_hot(input logic [N-1:0] v);
    return (v != '0) && ((v & (v - IDLE_HOT)) == '0);
  endfunction

  always_comb begin
    legal    = one_hot(st_q);
    step     = en && legal;
    wrap_evt = step && st_q[N-1];
    if (!legal)  st_nxt = IDLE_HOT;
    else if (en) st_nxt = {st_q[N-2:0], st_q[N-1]};
    else         st_nxt = st_q;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= IDLE_HOT;
    else     st_q <= st_nxt;
  end
endmodule

// File: rtl/pp_phase_dec.sv
module pp_phase_dec
  import pp_seq_pkg::*;
#(
  parameter int N    = 10,
  parameter int A_LO = 1,
  parameter int A_HI = 4,
  parameter int B_LO = 6,
  parameter int B_HI = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [N-1:0] st_nxt,
  input  logic         wrap_evt,
  output logic         hit_a,
  output logic         hit_b,
  output logic         drv_a,
  output logic         drv_b,
  output logic         cyc_strobe
);
  logic [N-1:0] sel_a;
  logic [N-1:0] sel_b;

  for (genvar i = 0; i < N; i++) begin : g_pos
    localparam grp_e G = grp_of(i, A_LO, A_HI, B_LO, B_HI);
    assign sel_a[i] = st_nxt[i] && (G == GRP_A);
    assign sel_b[i] = st_nxt[i] && (G == GRP_B);
  end

  assign hit_a = |sel_a;
  assign hit_b = |sel_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_a      <= 1'b0;
      drv_b      <= 1'b0;
      cyc_strobe <= 1'b0;
    end else begin
      drv_a      <= en && hit_a;
      drv_b      <= en && hit_b;
      cyc_strobe <= wrap_evt;
    end
  end
endmodule

// File: rtl/pp_drive_seq.sv
module pp_drive_seq #(
  parameter int N    = 10,
  parameter int A_LO = 1,
  parameter int A_HI = 4,
  parameter int B_LO = 6,
  parameter int B_HI = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic drv_a,
  output logic drv_b,
  output logic cyc_strobe
);
  logic [N-1:0] st_q;
  logic [N-1:0] st_nxt;
  logic         step;
  logic         wrap_evt;
  logic         hit_a;
  logic         hit_b;

  pp_ring #(.N(N)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .st_q     (st_q),
    .st_nxt   (st_nxt),
    .step     (step),
    .wrap_evt (wrap_evt)
  );

  pp_phase_dec #(
    .N(N), .A_LO(A_LO), .A_HI(A_HI), .B_LO(B_LO), .B_HI(B_HI)
  ) u_dec (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .st_nxt     (st_nxt),
    .wrap_evt   (wrap_evt),
    .hit_a      (hit_a),
    .hit_b      (hit_b),
    .drv_a      (drv_a),
    .drv_b      (drv_b),
    .cyc_strobe (cyc_strobe)
  );
endmodule

// File: rtl/pp_drive_seq_chk.sv
module pp_drive_seq_chk #(
  parameter int N = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         drv_a,
  input logic         drv_b,
  input logic         cyc_strobe,
  input logic [N-1:0] st_q,
  input logic         step,
  input logic         wrap_evt,
  input logic         hit_a,
  input logic         hit_b
);
  a_r1_onehot_state: assert property (@(posedge clk) disable iff (rst)
    $countones(st_q) == 1);

  a_r1_wrap_strobe: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> cyc_strobe);

  a_r1_step_moves: assert property (@(posedge clk) disable iff (rst)
    step |=> !$stable(st_q));

  a_r2_a_from_group: assert property (@(posedge clk) disable iff (rst)
    (en && hit_a) |=> drv_a);

  a_r3_b_from_group: assert property (@(posedge clk) disable iff (rst)
    (en && hit_b) |=> drv_b);

  a_r4_gap_before_a: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_a) |-> !$past(drv_b));

  a_r4_gap_before_b: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_b) |-> !$past(drv_a));

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(drv_a && drv_b));

  a_r7_hold_state: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(st_q));

  a_r7_silent_drives: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!drv_a && !drv_b && !cyc_strobe));

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    cyc_strobe |=> !cyc_strobe);
endmodule

bind pp_drive_seq pp_drive_seq_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .drv_a      (drv_a),
  .drv_b      (drv_b),
  .cyc_strobe (cyc_strobe),
  .st_q       (st_q),
  .step       (step),
  .wrap_evt   (wrap_evt),
  .hit_a      (hit_a),
  .hit_b      (hit_b)
);

// File: tb/pp_drive_seq_test.sv
`timescale 1ns/1ps
module pp_drive_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic drv_a, drv_b, cyc_strobe;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // reference model state
  int  ph = 0;
  logic ea = 1'b0, eb = 1'b0, es = 1'b0;
  logic prev_en = 1'b0, prev_rst = 1'b1, prev_strobe = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  pp_drive_seq uut (
    .clk(clk), .rst(rst), .en(en),
    .drv_a(drv_a), .drv_b(drv_b), .cyc_strobe(cyc_strobe)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%b expected=%b pos=%0d t=%0t", tag, what, act, exp, ph, $time);
    end
  endtask

  task automatic tick(input logic r, input logic e);
    string ta, tb, ts;
    logic resumed;
    rst = r;
    en  = e;
    @(posedge clk);
    resumed = e && !r && !prev_en && !prev_rst;
    if (r) begin
      ph = 0; ea = 0; eb = 0; es = 0;
    end else if (e) begin
      es = (ph == 9);
      ph = (ph + 1) % 10;
      ea = (ph >= 1 && ph <= 4);
      eb = (ph >= 6 && ph <= 9);
    end else begin
      ea = 0; eb = 0; es = 0;
    end
    @(negedge clk);
    if (r)            begin ta = "R6"; tb = "R6"; ts = "R6"; end
    else if (!e)      begin ta = "R7"; tb = "R7"; ts = "R7"; end
    else if (resumed) begin ta = "R8"; tb = "R8"; ts = "R8"; end
    else begin
      ta = (ph == 0 || ph == 5) ? "R4" : "R2";
      tb = (ph == 0 || ph == 5) ? "R4" : "R3";
      ts = "R1";
    end
    chk(ta, "drv_a", drv_a, ea);
    chk(tb, "drv_b", drv_b, eb);
    chk(ts, "cyc_strobe", cyc_strobe, es);
    chk("R5", "overlap", drv_a && drv_b, 1'b0);
    chk("R9", "strobe_repeat", prev_strobe && cyc_strobe, 1'b0);
    prev_strobe = cyc_strobe;
    prev_en  = e;
    prev_rst = r;
  endtask

  initial begin
    @(negedge clk);
    repeat (3) tick(1'b1, 1'b0);          // R6 reset state
    repeat (35) tick(1'b0, 1'b1);         // R1 R2 R3 R4 free run
    repeat (7) tick(1'b0, 1'b0);          // R7 hold mid-sequence
    repeat (12) tick(1'b0, 1'b1);         // R8 resume
    while (ph != 9) tick(1'b0, 1'b1);
    repeat (3) tick(1'b0, 1'b0);          // hold just before wrap
    repeat (5) tick(1'b0, 1'b1);          // R1 strobe on delayed wrap
    while (ph != 2) tick(1'b0, 1'b1);
    for (int i = 0; i < 40; i++) tick(1'b0, i[0]);
    for (int i = 0; i < 150; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(1'b0, lfsr[0] | lfsr[1]);
    end
    repeat (2) tick(1'b1, 1'b1);          // R6 reset wins over enable
    repeat (25) tick(1'b0, 1'b1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule